// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces a pulse-width-modulated bit from a wrapping sawtooth. An accumulator of `ACC_W` bits adds a programmable increment on every enabled clock and wraps modulo 2^ACC_W. The output bit is high while the accumulator is strictly below a programmable threshold. The increment sets the pulse rate, which is increment × f_clk / 2^ACC_W. The threshold sets the duty, which is threshold / 2^ACC_W. Both resolutions improve with every bit of accumulator width, so pulse rates that are not an integer division of the clock are possible.

The increment and threshold inputs are plain control words with no handshake. No data stream crosses the block, so it has no valid/ready interface. The block copies both words into holding registers on every clock. The words in force move from those registers only on a step whose addition carries out, which is the start of a new period, or while the block is disabled. A running waveform therefore never has a truncated period. A one-cycle strobe marks each period start. The accumulator value is brought out for phase-aligned consumers.

Top module: `pa_pwm_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `acc_o`, `pwm_o` and `wrap_o` are all 0.
- R2: On each clock edge with `en_i` high, `acc_o` becomes its previous value plus the increment in force, truncated to `ACC_W` bits.
- R3: On a clock edge with `en_i` low, `acc_o` keeps its value and `wrap_o` is 0.
- R4: `pwm_o` is 1 exactly when the value on `acc_o` is strictly less than the threshold in force, and 0 otherwise. The threshold is compared as an unsigned number of `ACC_W+1` bits.
- R5: `wrap_o` is 1 for the one cycle that follows an enabled step whose addition carried out of `ACC_W` bits, and 0 in every other cycle.
- R6: Starting from an accumulator of 0, k enabled steps with a fixed increment d produce exactly floor(k·d / 2^ACC_W) strobes on `wrap_o`. This holds for increments that do not divide 2^ACC_W.
- R7: A value is presented on `inc_i`/`thr_i` at one clock edge and captured into the holding registers. While enabled, it comes into force only at the next enabled step that carries, and it then governs `acc_o` and `pwm_o` from that step on. While disabled, it comes into force at the following edge. A change made at the carrying edge itself waits for the next carry.
- R8: A threshold of 0 keeps `pwm_o` at 0. A threshold of 2^ACC_W or more keeps `pwm_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Step enable; the accumulator freezes while low |
| inc_i | input | ACC_W | Phase increment word (pulse rate) |
| thr_i | input | ACC_W+1 | Duty threshold word; the MSB allows 2^ACC_W |
| pwm_o | output | 1 | PWM bit, registered |
| acc_o | output | ACC_W | Accumulator value, registered |
| wrap_o | output | 1 | Period-start strobe, one cycle |

## Verification
Two functions can meet in one clock edge. One is the carry that starts a new period. The other is the arrival of a new increment or threshold word. The bench provokes this by predicting the step that will carry and changing `inc_i` and `thr_i` in the cycle just before that edge. The edge then both emits the strobe and loads the earlier holding value. The newly presented word must stay pending for one more full period. A cycle-accurate reference, built from the requirements, judges `acc_o`, `pwm_o` and `wrap_o` each cycle across that collision and after it.

// File: rtl/pa_pwm_pkg.sv
package pa_pwm_pkg;
  // default accumulator width for the generator
  localparam int unsigned PA_DEF_ACC_W = 16;

  // source of the words in force after an edge
  typedef enum logic [0:0] {
    CFG_KEEP = 1'b0,
    CFG_LOAD = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/pa_cfg_regs.sv
module pa_cfg_regs
  import pa_pwm_pkg::*;
#(
  parameter int unsigned ACC_W = PA_DEF_ACC_W,
  localparam int unsigned THR_W = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [THR_W-1:0] thr_i,
  input  cfg_sel_e         sel_i,
  output logic [ACC_W-1:0] inc_act_o,
  output logic [THR_W-1:0] thr_act_o,
  output logic [THR_W-1:0] thr_nxt_o
);
  logic [ACC_W-1:0] inc_hold_q;
  logic [THR_W-1:0] thr_hold_q;
  logic [ACC_W-1:0] inc_act_q;
  logic [THR_W-1:0] thr_act_q;

  // holding stage: follows the inputs every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_hold_q <= '0;
      thr_hold_q <= '0;
    end else begin
      inc_hold_q <= inc_i;
      thr_hold_q <= thr_i;
    end
  end

  // words in force: move only on request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_act_q <= '0;
      thr_act_q <= '0;
    end else if (sel_i == CFG_LOAD) begin
      inc_act_q <= inc_hold_q;
      thr_act_q <= thr_hold_q;
    end
  end

  assign inc_act_o = inc_act_q;
  assign thr_act_o = thr_act_q;
  assign thr_nxt_o = (sel_i == CFG_LOAD) ? thr_hold_q : thr_act_q;
endmodule

// File: rtl/pa_accum.sv
module pa_accum #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] acc_nxt_o,
  output logic             carry_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] acc_q;
  logic             wrap_q;
  logic [ACC_W:0]   sum;

  assign sum       = {1'b0, acc_q} + {1'b0, inc_i};
  assign carry_o   = en_i & sum[ACC_W];
  assign acc_nxt_o = en_i ? sum[ACC_W-1:0] : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      acc_q  <= acc_nxt_o;
      wrap_q <= carry_o;
    end
  end

  assign acc_o  = acc_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/pa_cmp.sv
module pa_cmp #(
  parameter int unsigned ACC_W = 16,
  localparam int unsigned THR_W = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_nxt_i,
  input  logic [THR_W-1:0] thr_nxt_i,
  output logic             pwm_o
);
  logic pwm_q;
  logic below;

  // widen the phase so a threshold of 2^ACC_W and above is always greater
  assign below = ({1'b0, acc_nxt_i} < thr_nxt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= below;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pa_pwm_gen.sv
module pa_pwm_gen
  import pa_pwm_pkg::*;
#(
  parameter int unsigned ACC_W = PA_DEF_ACC_W,
  localparam int unsigned THR_W = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             pwm_o,
  output logic [ACC_W-1:0] acc_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] inc_act;
  logic [THR_W-1:0] thr_act;
  logic [THR_W-1:0] thr_nxt;
  logic [ACC_W-1:0] acc_nxt;
  logic             carry;
  cfg_sel_e         cfg_sel;

  // load words in force at a period start, or freely while stopped
  assign cfg_sel = (!en_i || carry) ? CFG_LOAD : CFG_KEEP;

  pa_cfg_regs #(.ACC_W(ACC_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (inc_i),
    .thr_i     (thr_i),
    .sel_i     (cfg_sel),
    .inc_act_o (inc_act),
    .thr_act_o (thr_act),
    .thr_nxt_o (thr_nxt)
  );

  pa_accum #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .inc_i     (inc_act),
    .acc_o     (acc_o),
    .acc_nxt_o (acc_nxt),
    .carry_o   (carry),
    .wrap_o    (wrap_o)
  );

  pa_cmp #(.ACC_W(ACC_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_nxt_i (acc_nxt),
    .thr_nxt_i (thr_nxt),
    .pwm_o     (pwm_o)
  );
endmodule

// File: rtl/pa_pwm_gen_chk.sv
module pa_pwm_gen_chk #(
  parameter int unsigned ACC_W = 16,
  localparam int unsigned THR_W = ACC_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             pwm_o,
  input logic [ACC_W-1:0] acc_o,
  input logic             wrap_o,
  input logic [ACC_W-1:0] inc_act,
  input logic [THR_W-1:0] thr_act
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) |-> acc_o == ACC_W'($past(acc_o) + $past(inc_act)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> ($stable(acc_o) && !wrap_o));

  p_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_o == ({1'b0, acc_o} < thr_act));

  p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> ($past(en_i) && (acc_o < $past(acc_o))));

  p_strobe_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && (acc_o < $past(acc_o))) |-> wrap_o);

  p_cfg_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && !wrap_o) |-> ($stable(inc_act) && $stable(thr_act)));

  p_zero_thr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_act == '0) |-> !pwm_o);
endmodule

bind pa_pwm_gen pa_pwm_gen_chk #(.ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (en_i),
  .pwm_o   (pwm_o),
  .acc_o   (acc_o),
  .wrap_o  (wrap_o),
  .inc_act (inc_act),
  .thr_act (thr_act)
);

// File: tb/pa_pwm_gen_bench.sv
module pa_pwm_gen_bench;
  localparam int W  = 8;
  localparam int TW = W + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_i = 1'b0;
  logic [W-1:0]  inc_i = '0;
  logic [TW-1:0] thr_i = '0;
  logic          pwm_o;
  logic [W-1:0]  acc_o;
  logic          wrap_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pa_pwm_gen #(.ACC_W(W)) u_pa_pwm_gen (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .inc_i(inc_i), .thr_i(thr_i),
    .pwm_o(pwm_o), .acc_o(acc_o), .wrap_o(wrap_o)
  );

  // reference built from the requirements
  logic [W-1:0]  m_hinc, m_inc, m_acc;
  logic [TW-1:0] m_hthr, m_thr;
  logic          m_wrap;
  logic [W:0]    m_sum;
  logic          m_carry, m_load;
  logic [W-1:0]  m_acc_n;
  logic [TW-1:0] m_thr_n;

  assign m_sum   = {1'b0, m_acc} + {1'b0, m_inc};
  assign m_carry = en_i & m_sum[W];
  assign m_load  = !en_i | m_carry;
  assign m_acc_n = en_i ? m_sum[W-1:0] : m_acc;
  assign m_thr_n = m_load ? m_hthr : m_thr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hinc <= '0; m_hthr <= '0; m_inc <= '0; m_thr <= '0;
      m_acc <= '0; m_wrap <= 1'b0;
    end else begin
      m_hinc <= inc_i;
      m_hthr <= thr_i;
      if (m_load) begin
        m_inc <= m_hinc;
        m_thr <= m_hthr;
      end
      m_acc  <= m_acc_n;
      m_wrap <= m_carry;
    end
  end

  function automatic logic exp_pwm();
    return {1'b0, m_acc} < m_thr;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle; compare all outputs with the reference at the falling edge
  task automatic step_cmp(input string req);
    @(negedge clk);
    check(acc_o == m_acc, req, "acc_o", acc_o, m_acc);
    check(pwm_o == exp_pwm(), req, "pwm_o", pwm_o, exp_pwm());
    check(wrap_o == m_wrap, req, "wrap_o", wrap_o, m_wrap);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en_i = 1'b0; inc_i = '0; thr_i = '0;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    check(acc_o == 0 && pwm_o == 0 && wrap_o == 0, "R1", "in reset",
          {acc_o, pwm_o, wrap_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(acc_o == 0 && pwm_o == 0 && wrap_o == 0, "R1", "after release",
          {acc_o, pwm_o, wrap_o}, 0);
  endtask

  // R2 R4 R5: steady running with a fractional rate
  task automatic sc_basic();
    inc_i = 8'd5; thr_i = 9'd100;
    repeat (2) step_cmp("R7");
    en_i = 1'b1;
    repeat (160) step_cmp("R2");
    thr_i = 9'd200; inc_i = 8'd37;
    repeat (80) step_cmp("R4");
  endtask

  // R6: strobe count over a window from zero
  task automatic sc_rate();
    int n;
    do_reset();
    inc_i = 8'd3; thr_i = 9'd128;
    repeat (2) @(negedge clk);      // words come into force while stopped
    en_i = 1'b1;
    n = 0;
    for (int k = 0; k < 256; k++) begin
      step_cmp("R6");
      if (wrap_o) n++;
    end
    check(n == 3, "R6", "strobes in 256 steps", n, 3);
    check(acc_o == 0, "R6", "phase back at zero", acc_o, 0);
  endtask

  // R3: disabled freezes phase and strobe
  task automatic sc_hold();
    logic [W-1:0] keep;
    en_i = 1'b1; inc_i = 8'd9;
    repeat (7) step_cmp("R2");
    en_i = 1'b0;
    @(negedge clk);
    keep = acc_o;
    for (int k = 0; k < 12; k++) begin
      step_cmp("R3");
      check(acc_o == keep && !wrap_o, "R3", "frozen acc", acc_o, keep);
    end
  endtask

  // R7: mid-period change waits for the carry
  task automatic sc_update();
    logic [W-1:0] a0;
    do_reset();
    inc_i = 8'd7; thr_i = 9'd64;
    repeat (2) @(negedge clk);
    en_i = 1'b1;
    repeat (5) step_cmp("R7");
    inc_i = 8'd20; thr_i = 9'd10;
    a0 = acc_o;
    step_cmp("R7");
    check(acc_o == W'(a0 + 7), "R7", "old increment still in force",
          acc_o, W'(a0 + 7));
    repeat (100) step_cmp("R7");
  endtask

  // R7: change presented on the carrying edge itself
  task automatic sc_collide();
    do_reset();
    inc_i = 8'd50; thr_i = 9'd30;
    repeat (2) @(negedge clk);
    en_i = 1'b1;
    while (!m_carry) step_cmp("R7");
    inc_i = 8'd90; thr_i = 9'd250;   // captured at the carrying edge
    step_cmp("R7");
    check(wrap_o == 1'b1, "R5", "strobe on collision", wrap_o, 1);
    repeat (60) step_cmp("R7");
  endtask

  // R8: threshold extremes
  task automatic sc_extremes();
    int hi;
    int lo;
    do_reset();
    inc_i = 8'd11; thr_i = 9'd0;
    repeat (2) @(negedge clk);
    en_i = 1'b1;
    hi = 0;
    for (int k = 0; k < 300; k++) begin
      step_cmp("R8");
      if (pwm_o) hi++;
    end
    check(hi == 0, "R8", "zero threshold high cycles", hi, 0);
    thr_i = 9'd256;
    while (!wrap_o) step_cmp("R8");
    while (!wrap_o || !(m_thr == 9'd256)) step_cmp("R8");
    lo = 0;
    for (int k = 0; k < 300; k++) begin
      step_cmp("R8");
      if (!pwm_o) lo++;
    end
    check(lo == 0, "R8", "full threshold low cycles", lo, 0);
  endtask

  initial begin
    do_reset();
    sc_basic();
    sc_hold();
    sc_rate();
    sc_update();
    sc_collide();
    sc_extremes();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule